// File: doc/BRIEF.md
# Load-Reserved / Store-Conditional Reservation Monitor

This block sits between one hart and a word-wide shared memory and gives that hart a reserved-load and conditional-store pair. A reserved load reads a word and arms a single reservation on that word. A later conditional store writes memory only if the reservation is still armed for the same word. It returns a status word: zero when the store took place and a fixed nonzero failure code when it did not. Plain loads and plain stores pass straight through to the memory.

The reservation is cancelled by several events. One is a store by another agent, which the block sees on a snoop input that carries only the address. Others are a trap taken by the hart, a context switch, a plain local store to the reserved word, and any conditional store, whether it succeeds or not. The block accepts one request per cycle with no back-pressure. Every request receives a registered response one cycle later. The memory is a single-port synchronous array that can map to block RAM.

Top module: `lrsc_monitor`

## Requirements
- R1: `req_op` encodes 0 = load, 1 = store, 2 = reserved load, 3 = conditional store. In the cycle after any request `rsp_valid` is high. For a load or a reserved load, `rsp_data` holds the word stored at the addressed word.
- R2: A snooped foreign store to the reserved word cancels the reservation, so the next conditional store fails. A snooped store to a different word leaves the reservation armed.
- R3: A successful conditional store writes `req_wdata` into memory. A failed one leaves memory unchanged.
- R4: A conditional store answers with `rsp_data` = 0 on success and `rsp_data` = FAIL_CODE (default 1) on failure. A plain store answers with `rsp_data` = 0.
- R5: A `trap` pulse cancels the reservation. A conditional store issued in the same cycle as `trap` fails.
- R6: A `ctx_switch` pulse cancels the reservation, so the next conditional store fails.
- R7: A conditional store to a word other than the reserved one fails and does not write either word.
- R8: A conditional store consumes the reservation whether it succeeds or fails. A second conditional store with no new reserved load fails.
- R9: When a snooped store and a conditional store hit the reserved word in the same cycle, the conditional store fails.
- R10: A plain local store to the reserved word cancels the reservation. A plain store to another word does not.
- R11: Addresses are byte addresses and are compared at word granularity. A conditional store at a different byte offset within the reserved word succeeds.
- R12: During and after reset `rsp_valid` is low and no reservation is armed. A reservation armed before a reset does not survive it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Hart request present this cycle |
| req_op | input | 2 | Operation code (see R1) |
| req_addr | input | ADDR_W | Byte address of the request |
| req_wdata | input | DATA_W | Store data for store and conditional store |
| snoop_valid | input | 1 | Another agent stores this cycle |
| snoop_addr | input | ADDR_W | Byte address of the foreign store |
| trap | input | 1 | Hart takes a trap this cycle |
| ctx_switch | input | 1 | Context switch this cycle |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_data | output | DATA_W | Read word or conditional-store status |

## Verification
The bench builds the block with ADDR_W = 8 and DATA_W = 32, which gives 64 words with two byte-offset bits. Words that differ and offsets within a single word are then both cheap to reach, so the word-granularity match and the wrong-word failure can each be exercised. FAIL_CODE stays at 1, so the failure status is checked against that value. Every cancelling event is driven between a reserved load and a conditional store, and the same-cycle races with a snoop or a trap are also driven. Memory is read back after each failed conditional store to confirm that nothing was written.

// File: rtl/lrsc_pkg.sv
package lrsc_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_LR    = 2'd2,
    OP_SC    = 2'd3
  } lrsc_op_e;

  typedef enum logic [1:0] {
    RK_MEM    = 2'd0,
    RK_STATUS = 2'd1,
    RK_ZERO   = 2'd2
  } rsp_kind_e;
endpackage

// File: rtl/lrsc_wordmem.sv
module lrsc_wordmem #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // single port, read-first, synchronous read: maps to block RAM
  always_ff @(posedge clk) begin
    if (we_i) mem[idx_i] <= wdata_i;
    rdata_o <= mem[idx_i];
  end
endmodule

// File: rtl/lrsc_resv.sv
module lrsc_resv #(
  parameter int IDX_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lr_i,
  input  logic             sc_i,
  input  logic             st_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             snoop_i,
  input  logic [IDX_W-1:0] snoop_idx_i,
  input  logic             trap_i,
  input  logic             ctx_i,
  output logic             sc_ok_o
);
  logic             valid_q;
  logic [IDX_W-1:0] idx_q;
  logic             cand_v;
  logic [IDX_W-1:0] cand_idx;
  logic             next_v;
  logic             snoop_hit_req;

  assign snoop_hit_req = snoop_i && (snoop_idx_i == idx_i);

  // foreign store, trap and context switch all beat a same-cycle conditional store
  assign sc_ok_o = sc_i && valid_q && (idx_q == idx_i) &&
                   !snoop_hit_req && !trap_i && !ctx_i;

  always_comb begin
    cand_v   = lr_i ? 1'b1  : valid_q;
    cand_idx = lr_i ? idx_i : idx_q;
    if (trap_i || ctx_i)                         next_v = 1'b0;
    else if (sc_i)                               next_v = 1'b0;
    else if (snoop_i && snoop_idx_i == cand_idx) next_v = 1'b0;
    else if (st_i && idx_i == cand_idx)          next_v = 1'b0;
    else                                         next_v = cand_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      valid_q <= next_v;
      idx_q   <= cand_idx;
    end
  end

  AST_TRAP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    trap_i |=> !valid_q); // R5
  AST_CTX_CLEARS: assert property (@(posedge clk) disable iff (rst)
    ctx_i |=> !valid_q); // R6
  AST_SC_CONSUMES: assert property (@(posedge clk) disable iff (rst)
    sc_i |=> !valid_q); // R8
  AST_SNOOP_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (snoop_i && valid_q && snoop_idx_i == idx_q && !lr_i) |=> !valid_q); // R2
  AST_STORE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (st_i && valid_q && idx_i == idx_q) |=> !valid_q); // R10
endmodule

// File: rtl/lrsc_rsp.sv
module lrsc_rsp
  import lrsc_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int FAIL_CODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_i,
  input  logic              is_sc_i,
  input  logic              is_st_i,
  input  logic              sc_ok_i,
  input  logic [DATA_W-1:0] mem_q_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);
  localparam logic [DATA_W-1:0] FAIL_WORD = DATA_W'(FAIL_CODE);

  logic      valid_q;
  rsp_kind_e kind_q;
  logic      fail_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      kind_q  <= RK_ZERO;
      fail_q  <= 1'b0;
    end else begin
      valid_q <= req_i;
      if (is_sc_i)      kind_q <= RK_STATUS;
      else if (is_st_i) kind_q <= RK_ZERO;
      else              kind_q <= RK_MEM;
      fail_q  <= !sc_ok_i;
    end
  end

  assign rsp_valid_o = valid_q;

  always_comb begin
    case (kind_q)
      RK_MEM:    rsp_data_o = mem_q_i;
      RK_STATUS: rsp_data_o = fail_q ? FAIL_WORD : '0;
      default:   rsp_data_o = '0;
    endcase
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
    req_i |=> rsp_valid_o); // R1
  AST_SC_FAIL_STATUS: assert property (@(posedge clk) disable iff (rst)
    (req_i && is_sc_i && !sc_ok_i) |=> (rsp_data_o == FAIL_WORD)); // R4
  AST_SC_OK_STATUS: assert property (@(posedge clk) disable iff (rst)
    (req_i && is_sc_i && sc_ok_i) |=> (rsp_data_o == '0)); // R4
endmodule

// File: rtl/lrsc_monitor.sv
module lrsc_monitor
  import lrsc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int FAIL_CODE = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              snoop_valid,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic              trap,
  input  logic              ctx_switch,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int OFF_W = $clog2(DATA_W / 8);
  localparam int IDX_W = ADDR_W - OFF_W;

  lrsc_op_e          op;
  logic [IDX_W-1:0]  req_idx;
  logic [IDX_W-1:0]  snoop_idx;
  logic              is_lr, is_sc, is_st;
  logic              sc_ok;
  logic              mem_we;
  logic [DATA_W-1:0] mem_q;

  assign op        = lrsc_op_e'(req_op);
  assign req_idx   = req_addr[ADDR_W-1:OFF_W];
  assign snoop_idx = snoop_addr[ADDR_W-1:OFF_W];
  assign is_lr     = req_valid && (op == OP_LR);
  assign is_sc     = req_valid && (op == OP_SC);
  assign is_st     = req_valid && (op == OP_STORE);
  assign mem_we    = is_st || sc_ok;

  lrsc_resv #(.IDX_W(IDX_W)) u_resv (
    .clk         (clk),
    .rst         (rst),
    .lr_i        (is_lr),
    .sc_i        (is_sc),
    .st_i        (is_st),
    .idx_i       (req_idx),
    .snoop_i     (snoop_valid),
    .snoop_idx_i (snoop_idx),
    .trap_i      (trap),
    .ctx_i       (ctx_switch),
    .sc_ok_o     (sc_ok)
  );

  lrsc_wordmem #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .idx_i   (req_idx),
    .wdata_i (req_wdata),
    .rdata_o (mem_q)
  );

  lrsc_rsp #(.DATA_W(DATA_W), .FAIL_CODE(FAIL_CODE)) u_rsp (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_valid),
    .is_sc_i     (is_sc),
    .is_st_i     (is_st),
    .sc_ok_i     (sc_ok),
    .mem_q_i     (mem_q),
    .rsp_valid_o (rsp_valid),
    .rsp_data_o  (rsp_data)
  );

  AST_FAILED_SC_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (is_sc && !sc_ok) |-> !mem_we); // R3
  AST_SAME_CYCLE_SNOOP: assert property (@(posedge clk) disable iff (rst)
    (is_sc && snoop_valid && snoop_idx == req_idx) |-> !sc_ok); // R9
endmodule

// File: tb/tb_lrsc_monitor.sv
module tb_lrsc_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [1:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          snoop_valid;
  logic [AW-1:0] snoop_addr;
  logic          trap;
  logic          ctx_switch;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lrsc_monitor #(.ADDR_W(AW), .DATA_W(DW), .FAIL_CODE(1)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .snoop_valid(snoop_valid),
    .snoop_addr(snoop_addr), .trap(trap), .ctx_switch(ctx_switch),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  localparam logic [1:0] LD = 2'd0, ST = 2'd1, LR = 2'd2, SC = 2'd3;

  task automatic chk(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 0; req_op = LD; req_addr = '0; req_wdata = '0;
    snoop_valid = 0; snoop_addr = '0; trap = 0; ctx_switch = 0;
  endtask

  task automatic issue(input logic [1:0] op, input logic [AW-1:0] a, input logic [DW-1:0] d,
                       input logic sv, input logic [AW-1:0] sa, input logic tr, input logic cs,
                       output logic [DW-1:0] r, output logic rv);
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d;
    snoop_valid = sv; snoop_addr = sa; trap = tr; ctx_switch = cs;
    @(negedge clk);
    r = rsp_data; rv = rsp_valid;
    idle_inputs();
  endtask

  task automatic op(input logic [1:0] o, input logic [AW-1:0] a, input logic [DW-1:0] d,
                    output logic [DW-1:0] r);
    logic rv;
    issue(o, a, d, 0, '0, 0, 0, r, rv);
  endtask

  task automatic side(input logic sv, input logic [AW-1:0] sa, input logic tr, input logic cs);
    @(negedge clk);
    snoop_valid = sv; snoop_addr = sa; trap = tr; ctx_switch = cs;
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic t_reset();
    logic [DW-1:0] r;
    rst = 1; idle_inputs();
    repeat (3) @(negedge clk);
    chk("R12 rsp_valid in reset", {31'b0, rsp_valid}, 0);
    rst = 0;
    @(negedge clk);
    chk("R12 rsp_valid after reset", {31'b0, rsp_valid}, 0);
    op(ST, 8'h04, 32'h1111_0000, r);
    op(SC, 8'h04, 32'hDEAD_0001, r);
    chk("R12 no reservation after reset", r, 1);
    op(LD, 8'h04, 0, r);
    chk("R12 memory untouched", r, 32'h1111_0000);
  endtask

  task automatic t_load_basic();
    logic [DW-1:0] r; logic rv;
    issue(ST, 8'h10, 32'hA5A5_0010, 0, '0, 0, 0, r, rv);
    chk("R4 store response data", r, 0);
    chk("R1 store rsp_valid", {31'b0, rv}, 1);
    issue(LD, 8'h10, 0, 0, '0, 0, 0, r, rv);
    chk("R1 load data", r, 32'hA5A5_0010);
    chk("R1 load rsp_valid", {31'b0, rv}, 1);
    issue(LR, 8'h10, 0, 0, '0, 0, 0, r, rv);
    chk("R1 reserved load data", r, 32'hA5A5_0010);
    op(SC, 8'h10, 32'h0000_BEEF, r);
    chk("R4 sc success status", r, 0);
    op(LD, 8'h10, 0, r);
    chk("R3 sc wrote memory", r, 32'h0000_BEEF);
  endtask

  task automatic t_snoop();
    logic [DW-1:0] r;
    op(ST, 8'h20, 32'h2020_2020, r);
    op(LR, 8'h20, 0, r);
    side(1, 8'h21, 0, 0);
    op(SC, 8'h20, 32'h1234_5678, r);
    chk("R2 snoop hit fails sc", r, 1);
    op(LD, 8'h20, 0, r);
    chk("R3 failed sc no write", r, 32'h2020_2020);
    op(LR, 8'h20, 0, r);
    side(1, 8'h30, 0, 0);
    op(SC, 8'h20, 32'h3333_3333, r);
    chk("R2 snoop other word keeps", r, 0);
  endtask

  task automatic t_trap_ctx();
    logic [DW-1:0] r; logic rv;
    op(ST, 8'h40, 32'h4040_4040, r);
    op(LR, 8'h40, 0, r);
    side(0, '0, 1, 0);
    op(SC, 8'h40, 32'h5, r);
    chk("R5 trap between fails", r, 1);
    op(LR, 8'h40, 0, r);
    issue(SC, 8'h40, 32'h6, 0, '0, 1, 0, r, rv);
    chk("R5 trap same cycle fails", r, 1);
    op(LR, 8'h40, 0, r);
    side(0, '0, 0, 1);
    op(SC, 8'h40, 32'h7, r);
    chk("R6 ctx switch fails", r, 1);
    op(LD, 8'h40, 0, r);
    chk("R3 memory kept after failures", r, 32'h4040_4040);
  endtask

  task automatic t_wrong_addr_and_consume();
    logic [DW-1:0] r;
    op(ST, 8'h50, 32'h5050_5050, r);
    op(ST, 8'h54, 32'h5454_5454, r);
    op(LR, 8'h50, 0, r);
    op(SC, 8'h54, 32'h9999_9999, r);
    chk("R7 sc other word fails", r, 1);
    op(LD, 8'h54, 0, r);
    chk("R7 other word unchanged", r, 32'h5454_5454);
    op(SC, 8'h50, 32'h8888_8888, r);
    chk("R8 reservation consumed by failed sc", r, 1);
    op(LR, 8'h50, 0, r);
    op(SC, 8'h50, 32'h7777_7777, r);
    chk("R8 first sc ok", r, 0);
    op(SC, 8'h50, 32'h6666_6666, r);
    chk("R8 second sc fails", r, 1);
    op(LD, 8'h50, 0, r);
    chk("R8 second sc no write", r, 32'h7777_7777);
  endtask

  task automatic t_same_cycle_snoop();
    logic [DW-1:0] r; logic rv;
    op(ST, 8'h60, 32'h6060_6060, r);
    op(LR, 8'h60, 0, r);
    issue(SC, 8'h60, 32'hABCD_0000, 1, 8'h62, 0, 0, r, rv);
    chk("R9 same-cycle snoop fails sc", r, 1);
    op(LD, 8'h60, 0, r);
    chk("R9 memory unchanged", r, 32'h6060_6060);
  endtask

  task automatic t_local_store();
    logic [DW-1:0] r;
    op(LR, 8'h70, 0, r);
    op(ST, 8'h70, 32'h7070_7070, r);
    op(SC, 8'h70, 32'h1, r);
    chk("R10 local store clears", r, 1);
    op(LR, 8'h70, 0, r);
    op(ST, 8'h74, 32'h7474_7474, r);
    op(SC, 8'h70, 32'h2, r);
    chk("R10 store other word keeps", r, 0);
  endtask

  task automatic t_granularity();
    logic [DW-1:0] r;
    op(LR, 8'h80, 0, r);
    op(SC, 8'h83, 32'hCAFE_F00D, r);
    chk("R11 offset within word ok", r, 0);
    op(LD, 8'h81, 0, r);
    chk("R11 word written", r, 32'hCAFE_F00D);
  endtask

  task automatic t_reset_drops();
    logic [DW-1:0] r;
    op(LR, 8'h90, 0, r);
    @(negedge clk); rst = 1;
    @(negedge clk); @(negedge clk); rst = 0;
    op(SC, 8'h90, 32'h1, r);
    chk("R12 reset drops reservation", r, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_load_basic();
    t_snoop();
    t_trap_ctx();
    t_wrong_addr_and_consume();
    t_same_cycle_snoop();
    t_local_store();
    t_granularity();
    t_reset_drops();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule